// File: doc/BRIEF.md
# SDH Receive Frame Aligner

This block sits at the head of a synchronous line receiver, after byte recovery and ahead of descrambling. It takes bytes that carry no frame boundary information and looks for the run of framing bytes that opens each frame. The run is a group of F6h bytes followed by an equal group of 28h bytes. With one lane the group is three bytes; with N interleaved lanes it is 3×N bytes. The frame is a grid of rows and columns sent row after row, with columns running left to right. Once the run is found, the block numbers every later byte with its row and column. It marks the first byte after the framing run as the start of a frame.

Alignment is declared only after the pattern shows up twice at the expected place, one frame apart. After that, the block drops back to hunting only when several frames in a row carry a broken pattern. A persistence timer, counted in frame periods, raises loss-of-frame when out-of-frame lasts too long. It clears loss-of-frame after an equally long stretch in frame. While loss-of-frame is active, every output byte is replaced by FFh so that downstream logic sees an all-ones signal.

Top module: `sdh_frame_aligner`

## Requirements
- R1: After reset, `oof` is 1, `lof` is 0, `alValid` is 0 and `alFrameStart` is 0; the block is hunting.
- R2: While hunting, a byte is the end of a framing run when it and the previous 2A-1 bytes read A bytes of F6h and then A bytes of 28h (A = 3×N). That byte is reported at row 0, column 2A-1. Each later valid byte advances the column; after column COLS-1 the column returns to 0 and the row advances, and after row ROWS-1 the row returns to 0.
- R3: A hunting match counts as the first good frame. When the next frame also carries the full run ending at row 0, column 2A-1, `oof` falls on that byte.
- R4: While in frame, one to three consecutive frames with a broken run at the expected place leave `oof` at 0 and the numbering unchanged. A correct frame restarts the error run.
- R5: The fourth consecutive frame with a broken run sets `oof` to 1 and the block resumes hunting on the following bytes.
- R6: `alFrameStart` is 1 exactly with the byte at row 0, column 2A, and only while `oof` was 0 when that byte arrived.
- R7: A frame period ends with the byte at row ROWS-1, column COLS-1. Once `oof` has been 1 without a break for `lofFrames` frame periods, `lof` rises.
- R8: Once `oof` has been 0 without a break for `lofFrames` frame periods, `lof` falls.
- R9: Each byte that arrives while `lof` is 1 leaves the block as FFh. Its row and column numbering continues.
- R10: `alValid` repeats `rxValid` one clock later. Cycles with `rxValid` at 0 neither advance the numbering nor count toward any frame check.
- R11: After a hunting match, if the next frame does not carry the run at the expected place, `oof` stays 1 and hunting resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxData | input | 8 | Unaligned received byte |
| rxValid | input | 1 | rxData carries a byte this cycle |
| lofFrames | input | PERSIST_W | Loss-of-frame persistence in frame periods (24 for 3 ms); values below 1 act as 1 |
| alData | output | 8 | Delayed byte, FFh while loss-of-frame |
| alValid | output | 1 | alData, alRow, alCol are meaningful |
| alRow | output | clog2(ROWS) | Row index of alData |
| alCol | output | clog2(COLS) | Column index of alData |
| alFrameStart | output | 1 | First byte after the framing run |
| oof | output | 1 | Out of frame |
| lof | output | 1 | Loss of frame |

## Verification
The bench builds the block with 3 rows, a base width of 12 columns and one framing byte per group, using two lanes. That gives 24 columns, a four-byte run and a 72-byte frame, with `lofFrames` set to 3. With these values, loss-of-frame can be raised and cleared, four-frame error runs can be built and misaligned streams can be re-acquired, all within a few thousand bytes. Random idle cycles between bytes show that the numbering and the frame checks depend only on valid bytes. Random payload and hunting noise drive the state machine through hunting, confirmation and lock.

// File: rtl/sdh_fa_pkg.sv
package sdh_fa_pkg;
  localparam logic [7:0] FRAMING_HI = 8'hF6;
  localparam logic [7:0] FRAMING_LO = 8'h28;

  typedef struct packed {
    logic realign;
    logic oof;
    logic lof;
  } ctrlStrobe_t;

  typedef struct packed {
    logic byteValid;
    logic patMatch;
    logic atCheck;
    logic frameTick;
  } dpFlag_t;
endpackage

// File: rtl/fa_datapath.sv
module fa_datapath
  import sdh_fa_pkg::*;
#(
  parameter int ROWS    = 9,
  parameter int COLS    = 270,
  parameter int A_BYTES = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [7:0]               rxData,
  input  logic                     rxValid,
  input  ctrlStrobe_t              ctrl,
  output dpFlag_t                  flags,
  output logic [7:0]               alData,
  output logic                     alValid,
  output logic [$clog2(ROWS)-1:0]  alRow,
  output logic [$clog2(COLS)-1:0]  alCol,
  output logic                     alFrameStart
);
  localparam int WIN = 2 * A_BYTES;
  localparam int RW  = $clog2(ROWS);
  localparam int CW  = $clog2(COLS);

  logic [7:0]    hist [WIN-1];
  logic [7:0]    winByte [WIN];
  logic [WIN-1:0] hitVec;
  logic [RW-1:0] rowCnt, curRow, nxtRow;
  logic [CW-1:0] colCnt, curCol, nxtCol;
  logic          atStart;

  always_comb begin
    for (int i = 0; i < WIN - 1; i++) winByte[i] = hist[i];
    winByte[WIN-1] = rxData;
  end

  for (genvar g = 0; g < WIN; g++) begin : g_cmp
    if (g < A_BYTES) begin : g_hi
      assign hitVec[g] = (winByte[g] == FRAMING_HI);
    end else begin : g_lo
      assign hitVec[g] = (winByte[g] == FRAMING_LO);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WIN - 1; i++) hist[i] <= '0;
    end else if (rxValid) begin
      for (int i = 0; i < WIN - 2; i++) hist[i] <= hist[i+1];
      hist[WIN-2] <= rxData;
    end
  end

  always_comb begin
    curRow = ctrl.realign ? '0 : rowCnt;
    curCol = ctrl.realign ? CW'(WIN - 1) : colCnt;
    if (curCol == CW'(COLS - 1)) begin
      nxtCol = '0;
      nxtRow = (curRow == RW'(ROWS - 1)) ? '0 : curRow + 1'b1;
    end else begin
      nxtCol = curCol + 1'b1;
      nxtRow = curRow;
    end
  end

  assign atStart = (curRow == '0) && (curCol == CW'(WIN));

  assign flags.byteValid = rxValid;
  assign flags.patMatch  = &hitVec;
  assign flags.atCheck   = (curRow == '0) && (curCol == CW'(WIN - 1));
  assign flags.frameTick = (curRow == RW'(ROWS - 1)) && (curCol == CW'(COLS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowCnt <= '0;
      colCnt <= '0;
    end else if (rxValid) begin
      rowCnt <= nxtRow;
      colCnt <= nxtCol;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alValid      <= 1'b0;
      alData       <= '0;
      alRow        <= '0;
      alCol        <= '0;
      alFrameStart <= 1'b0;
    end else begin
      alValid      <= rxValid;
      alFrameStart <= rxValid && !ctrl.oof && atStart;
      if (rxValid) begin
        alData <= ctrl.lof ? 8'hFF : rxData;
        alRow  <= curRow;
        alCol  <= curCol;
      end
    end
  end

  // R9
  lofFill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && ctrl.lof) |=> (alData == 8'hFF));

  // R2
  range_chk: assert property (@(posedge clk) disable iff (!rstN)
    alValid |-> ((int'(alRow) < ROWS) && (int'(alCol) < COLS)));

  // R2
  realign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && ctrl.realign) |=> (alRow == '0 && alCol == CW'(WIN - 1)));

  // R6
  frameStart_chk: assert property (@(posedge clk) disable iff (!rstN)
    alFrameStart |-> (alValid && alRow == '0 && alCol == CW'(WIN)));
endmodule

// File: rtl/fa_control.sv
module fa_control
  import sdh_fa_pkg::*;
#(
  parameter int PERSIST_W   = 8,
  parameter int ERR_FRAMES  = 4,
  parameter int GOOD_FRAMES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpFlag_t              flags,
  input  logic [PERSIST_W-1:0] lofFrames,
  output ctrlStrobe_t          ctrl
);
  localparam int BW = $clog2(ERR_FRAMES + 1);
  localparam int GW = $clog2(GOOD_FRAMES + 1);

  typedef enum logic [1:0] {HUNT, VERIFY, LOCKED} alignState_t;

  alignState_t          state;
  logic [BW-1:0]        badCnt;
  logic [GW-1:0]        goodCnt;
  logic [PERSIST_W-1:0] persistCnt;
  logic                 lofReg;
  logic                 persistCond;
  logic                 checkByte;

  assign ctrl.realign = (state == HUNT) && flags.patMatch && flags.byteValid;
  assign ctrl.oof     = (state != LOCKED);
  assign ctrl.lof     = lofReg;
  assign checkByte    = flags.byteValid && flags.atCheck;
  assign persistCond  = lofReg ? (state == LOCKED) : (state != LOCKED);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= HUNT;
      badCnt  <= '0;
      goodCnt <= '0;
    end else begin
      unique case (state)
        HUNT: if (ctrl.realign) begin
          if (GOOD_FRAMES <= 1) begin
            state  <= LOCKED;
            badCnt <= '0;
          end else begin
            state   <= VERIFY;
            goodCnt <= GW'(1);
          end
        end
        VERIFY: if (checkByte) begin
          if (!flags.patMatch) begin
            state <= HUNT;
          end else if (goodCnt + 1'b1 >= GW'(GOOD_FRAMES)) begin
            state  <= LOCKED;
            badCnt <= '0;
          end else begin
            goodCnt <= goodCnt + 1'b1;
          end
        end
        LOCKED: if (checkByte) begin
          if (flags.patMatch) begin
            badCnt <= '0;
          end else if (badCnt + 1'b1 >= BW'(ERR_FRAMES)) begin
            state <= HUNT;
          end else begin
            badCnt <= badCnt + 1'b1;
          end
        end
        default: state <= HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lofReg     <= 1'b0;
      persistCnt <= '0;
    end else if (!persistCond) begin
      persistCnt <= '0;
    end else if (flags.byteValid && flags.frameTick) begin
      if (({1'b0, persistCnt} + 1'b1) >= {1'b0, lofFrames}) begin
        lofReg     <= ~lofReg;
        persistCnt <= '0;
      end else begin
        persistCnt <= persistCnt + 1'b1;
      end
    end
  end

  // R3
  oofFall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrl.oof) |-> $past(flags.byteValid && flags.atCheck && flags.patMatch));

  // R5
  oofRise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrl.oof) |-> $past(flags.byteValid && flags.atCheck && !flags.patMatch));

  // R7
  lofRise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrl.lof) |-> $past(ctrl.oof && flags.byteValid && flags.frameTick));

  // R8
  lofFall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrl.lof) |-> $past(!ctrl.oof && flags.byteValid && flags.frameTick));
endmodule

// File: rtl/sdh_frame_aligner.sv
module sdh_frame_aligner
  import sdh_fa_pkg::*;
#(
  parameter int ROWS        = 9,
  parameter int BASE_COLS   = 270,
  parameter int BASE_A      = 3,
  parameter int LANES       = 1,
  parameter int PERSIST_W   = 8,
  parameter int ERR_FRAMES  = 4,
  parameter int GOOD_FRAMES = 2
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [7:0]                            rxData,
  input  logic                                  rxValid,
  input  logic [PERSIST_W-1:0]                  lofFrames,
  output logic [7:0]                            alData,
  output logic                                  alValid,
  output logic [$clog2(ROWS)-1:0]               alRow,
  output logic [$clog2(BASE_COLS*LANES)-1:0]    alCol,
  output logic                                  alFrameStart,
  output logic                                  oof,
  output logic                                  lof
);
  localparam int COLS    = BASE_COLS * LANES;
  localparam int A_BYTES = BASE_A * LANES;

  ctrlStrobe_t ctrl;
  dpFlag_t     flags;

  fa_datapath #(.ROWS(ROWS), .COLS(COLS), .A_BYTES(A_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxValid(rxValid),
    .ctrl(ctrl), .flags(flags), .alData(alData), .alValid(alValid),
    .alRow(alRow), .alCol(alCol), .alFrameStart(alFrameStart)
  );

  fa_control #(.PERSIST_W(PERSIST_W), .ERR_FRAMES(ERR_FRAMES),
               .GOOD_FRAMES(GOOD_FRAMES)) ctl_i (
    .clk(clk), .rstN(rstN), .flags(flags), .lofFrames(lofFrames), .ctrl(ctrl)
  );

  assign oof = ctrl.oof;
  assign lof = ctrl.lof;
endmodule

// File: tb/sdh_frame_aligner_tb.sv
module sdh_frame_aligner_tb_top;
  localparam int ROWS  = 3;
  localparam int BCOLS = 12;
  localparam int BA    = 1;
  localparam int LANES = 2;
  localparam int COLS  = BCOLS * LANES;
  localparam int A     = BA * LANES;
  localparam int WIN   = 2 * A;
  localparam int PW    = 8;
  localparam int LIMIT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] rxData = '0;
  logic rxValid = 1'b0;
  logic [PW-1:0] lofFrames = PW'(LIMIT);
  logic [7:0] alData;
  logic alValid;
  logic [$clog2(ROWS)-1:0] alRow;
  logic [$clog2(COLS)-1:0] alCol;
  logic alFrameStart, oof, lof;

  always #4 clk = ~clk;

  sdh_frame_aligner #(.ROWS(ROWS), .BASE_COLS(BCOLS), .BASE_A(BA), .LANES(LANES),
                      .PERSIST_W(PW)) dut_i (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxValid(rxValid), .lofFrames(lofFrames),
    .alData(alData), .alValid(alValid), .alRow(alRow), .alCol(alCol),
    .alFrameStart(alFrameStart), .oof(oof), .lof(lof)
  );

  int nRun = 0, nFail = 0;
  bit done = 0;

  // reference state, expressed in requirement terms
  logic [7:0] mHist [WIN-1];
  int mRow = 0, mCol = 0, mState = 0, mGood = 0, mBad = 0, mCnt = 0;
  bit mLof = 0;
  bit pValid = 0, pFs = 0, pMasked = 0;
  logic [7:0] pData = '0;
  int pRow = 0, pCol = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit isRun(input logic [7:0] b);
    bit ok = 1;
    for (int i = 0; i < WIN; i++) begin
      logic [7:0] v = (i == WIN - 1) ? b : mHist[i];
      if (v != ((i < A) ? 8'hF6 : 8'h28)) ok = 0;
    end
    return ok;
  endfunction

  task automatic modelByte(input logic [7:0] b);
    bit m = isRun(b);
    bit re = (mState == 0) && m;
    int r = re ? 0 : mRow;
    int c = re ? WIN - 1 : mCol;
    bit atChk = (r == 0) && (c == WIN - 1);
    bit tick = (r == ROWS - 1) && (c == COLS - 1);
    bit cond = mLof ? (mState == 2) : (mState != 2);
    pData = mLof ? 8'hFF : b;
    pMasked = mLof;
    pRow = r; pCol = c;
    pFs = (mState == 2) && (r == 0) && (c == WIN);
    if (!cond) mCnt = 0;
    else if (tick) begin
      if (mCnt + 1 >= LIMIT) begin mLof = !mLof; mCnt = 0; end
      else mCnt++;
    end
    case (mState)
      0: if (re) begin mState = 1; mGood = 1; end
      1: if (atChk) begin
           if (!m) mState = 0;
           else if (mGood + 1 >= 2) begin mState = 2; mBad = 0; end
           else mGood++;
         end
      default: if (atChk) begin
           if (m) mBad = 0;
           else if (mBad + 1 >= 4) mState = 0;
           else mBad++;
         end
    endcase
    for (int i = 0; i < WIN - 2; i++) mHist[i] = mHist[i+1];
    mHist[WIN-2] = b;
    if (c == COLS - 1) begin mCol = 0; mRow = (r == ROWS - 1) ? 0 : r + 1; end
    else begin mCol = c + 1; mRow = r; end
  endtask

  task automatic checkPending();
    chk(alValid == pValid, "R10 valid", alValid, pValid);
    if (pValid) begin
      chk(alData == pData, pMasked ? "R9 data" : "R2 data", alData, pData);
      chk(int'(alRow) == pRow, "R2 row", alRow, pRow);
      chk(int'(alCol) == pCol, "R2 col", alCol, pCol);
      chk(alFrameStart == pFs, "R6 frameStart", alFrameStart, pFs);
    end
    chk(oof == (mState != 2), (mState != 2) ? "R5 oof" : "R4 oof", oof, mState != 2);
    chk(lof == mLof, mLof ? "R7 lof" : "R8 lof", lof, mLof);
  endtask

  task automatic sendByte(input bit v, input logic [7:0] b);
    @(negedge clk);
    checkPending();
    rxValid = v;
    rxData = b;
    pValid = v;
    if (v) modelByte(b);
  endtask

  task automatic sendGapped(input logic [7:0] b);
    if ($urandom % 8 == 0) sendByte(0, 8'($urandom));
    sendByte(1, b);
  endtask

  task automatic sendFrame(input bit broken);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        logic [7:0] b = 8'($urandom);
        if (r == 0 && c < WIN) b = (c < A) ? 8'hF6 : 8'h28;
        if (broken && r == 0 && c == A) b = 8'h29;
        sendGapped(b);
      end
  endtask

  task automatic sendNoise(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = 8'($urandom);
      if (b == 8'hF6) b = 8'h00;
      sendGapped(b);
    end
  endtask

  task automatic settle();
    sendByte(0, 8'h00);
    sendByte(0, 8'h00);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < WIN - 1; i++) mHist[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(oof == 1'b1, "R1 oof", oof, 1);
    chk(lof == 1'b0, "R1 lof", lof, 0);
    chk(alValid == 1'b0, "R1 valid", alValid, 0);
    chk(alFrameStart == 1'b0, "R1 frameStart", alFrameStart, 0);
    rstN = 1'b1;

    sendNoise(4 * ROWS * COLS + 5);
    settle();
    chk(lof == 1'b1, "R7 lof raised by noise", lof, 1);

    sendFrame(0);
    settle();
    chk(oof == 1'b1, "R3 one match not enough", oof, 1);
    sendFrame(0);
    settle();
    chk(oof == 1'b0, "R3 locked after two", oof, 0);
    for (int k = 0; k < LIMIT + 1; k++) sendFrame(0);
    settle();
    chk(lof == 1'b0, "R8 lof cleared", lof, 0);

    for (int k = 0; k < 3; k++) sendFrame(1);
    sendFrame(0);
    for (int k = 0; k < 3; k++) sendFrame(1);
    settle();
    chk(oof == 1'b0, "R4 three errored frames tolerated", oof, 0);
    sendFrame(1);
    settle();
    chk(oof == 1'b1, "R5 fourth errored frame", oof, 1);

    for (int k = 0; k < 3; k++) sendFrame(0);
    settle();
    chk(oof == 1'b0, "R2 reacquired", oof, 0);

    sendNoise(7);
    for (int k = 0; k < 6; k++) sendFrame(0);
    settle();
    chk(oof == 1'b0, "R2 slip recovered", oof, 0);

    for (int k = 0; k < 4; k++) sendFrame(1);
    sendNoise(ROWS * COLS - 3);
    sendFrame(0);
    sendFrame(1);
    settle();
    chk(oof == 1'b1, "R11 unconfirmed match", oof, 1);
    for (int k = 0; k < LIMIT + 3; k++) sendFrame(0);
    settle();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule